// File: doc/BRIEF.md
# Link Training Watchdog with Stall Recovery

This block supervises a serial link once training has been switched on. After a start pulse it checks the link repeatedly. In each check it looks at two debug status words from the link controller. If the link is not up, it also reads one receiver status register in the PHY through a request/acknowledge register port. The block reports a successful link on `link_up`. It reports a link that never comes up on `link_fail`. Either status holds until the next start.

One failure case gets special handling. During the speed change to the second generation, the link can sit in the receiver-lock recovery state while the PHY reports no valid receive data. When the watchdog sees this combination, it self-heals. It reads the PHY receiver override register, forces the receiver PLL enable and data enable on, and writes the value back. It holds this for a fixed interval, then reads the register again, clears the two enables, and writes it back. The start of each such recovery is marked by a one-cycle `stuck_event`.

All intervals come from a cycle-per-microsecond prescaler parameter, so a bench can shrink them. The status bit positions, PHY addresses and the override mask are parameters.

Top module: `lnk_train_guard`

## Requirements
- R1: One cycle after `start`, a check samples `dbg_word1`. The link counts as up only when bit 4 is 1 and bit 29 (training in progress) is 0. In that case `link_up` rises on the next cycle and stays high until the next `start`.
- R2: When a check finds the link not up, the block issues one PHY read of address 0x100D. Every PHY transaction keeps `phy_req` high, with `phy_addr`, `phy_we` and `phy_wdata` unchanged, up to and including the cycle in which `phy_ack` is high. That cycle completes the transaction.
- R3: Recovery is skipped, and the block goes straight to the poll wait, when bit 0 of the 0x100D read data (receive valid) is 1. It is also skipped when `dbg_word0[5:0]` at the acknowledge cycle differs from 0x0D (receiver-lock recovery state).
- R4: When receive valid is 0 and the state field equals 0x0D, `stuck_event` is high for exactly one cycle. In that same cycle the block starts a read of address 0x1005. It then writes back the read data with bits 5 and 3 set.
- R5: After that write is acknowledged, the block waits HOLD_US*CYC_PER_US cycles. It then reads 0x1005 again and writes back the read data with bits 5 and 3 cleared, leaving every other bit unchanged.
- R6: Each unsuccessful check ends in a wait of POLL_US*CYC_PER_US cycles before the next check. When MAX_POLLS checks in a row have failed, `link_fail` rises and holds until the next `start`. `link_up` and `link_fail` are never high together.
- R7: After reset, all outputs are 0. A `start` in any state abandons the current activity, clears both status outputs and the poll count, and begins a new check on the next cycle.
- R8: While idle, and while `link_up` or `link_fail` is high, `phy_req` stays 0 and the block issues no PHY traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) monitoring |
| dbg_word0 | input | DBG_W | Controller debug word carrying the link state field |
| dbg_word1 | input | DBG_W | Controller debug word carrying link-up and training flags |
| phy_req | output | 1 | PHY register transaction request |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | PHY_AW | PHY register address (0 when no request) |
| phy_wdata | output | PHY_DW | Write data (0 when not writing) |
| phy_ack | input | 1 | Transaction complete in this cycle |
| phy_rdata | input | PHY_DW | Read data, valid with `phy_ack` |
| link_up | output | 1 | Link trained, held until next start |
| link_fail | output | 1 | Poll budget exhausted, held until next start |
| stuck_event | output | 1 | One-cycle pulse at the start of each recovery |

## Verification
The in-RTL properties watch several things on every cycle. They check that `phy_req` and its address and data stay stable until acknowledged. They check that the two status flags are exclusive and sticky until start, and that no PHY traffic appears while a status is held. They check that `stuck_event` is a single-cycle pulse that coincides with a read of the override register. Some properties cannot be expressed that way and are shown only by the bench's scenarios. These are the exact read-modify-write values written to the override register, the length of the hold and poll intervals, and the poll count at which failure is declared. The scenarios also cover the choice between skipping and running recovery under each combination of receive valid and state field, and a restart in the middle of a hold.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RX_RD,
      ST_OV_RD1,
      ST_OV_WR1,
      ST_HOLD,
      ST_OV_RD2,
      ST_OV_WR2,
      ST_WAIT
   } guard_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_RD_RX,
      OP_RD_OVR,
      OP_WR_OVR
   } phy_op_e;

endpackage

// File: rtl/lnk_dbg_decode.sv
module lnk_dbg_decode #(
   parameter int DBG_W       = 32,
   parameter int UP_BIT      = 4,
   parameter int TRAIN_BIT   = 29,
   parameter int STATE_LSB   = 0,
   parameter int STATE_W     = 6,
   parameter int STALL_STATE = 13
) (
   input  logic [DBG_W-1:0] dbg0,
   input  logic [DBG_W-1:0] dbg1,
   output logic             link_ok,
   output logic             at_stall
);
   localparam logic [STATE_W-1:0] STALL_CODE = STATE_W'(STALL_STATE);

   logic [STATE_W-1:0] state_field;
   logic               unused_dbg_bits;

   assign state_field     = dbg0[STATE_LSB +: STATE_W];
   assign link_ok         = dbg1[UP_BIT] & ~dbg1[TRAIN_BIT];
   assign at_stall        = (state_field == STALL_CODE);
   assign unused_dbg_bits = ^{dbg0, dbg1};

endmodule

// File: rtl/lnk_interval_timer.sv
module lnk_interval_timer #(
   parameter int CYC_PER_US = 100,
   parameter int POLL_US    = 10,
   parameter int HOLD_US    = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_poll,
   input  logic load_hold,
   output logic done
);
   localparam int MAX_US = (POLL_US > HOLD_US) ? POLL_US : HOLD_US;
   localparam int UW     = $clog2(MAX_US + 1);

   if (CYC_PER_US == 1) begin : g_direct
      logic [UW-1:0] us_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            us_q <= '0;
         else if (load_poll)    us_q <= UW'(POLL_US - 1);
         else if (load_hold)    us_q <= UW'(HOLD_US - 1);
         else if (us_q != '0)   us_q <= us_q - 1'b1;
      end
      assign done = (us_q == '0);
   end else begin : g_prescaled
      localparam int PW = $clog2(CYC_PER_US);
      localparam logic [PW-1:0] PRE_TOP = PW'(CYC_PER_US - 1);
      logic [PW-1:0] pre_q;
      logic [UW-1:0] us_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
         end else if (load_poll) begin
            pre_q <= PRE_TOP;
            us_q  <= UW'(POLL_US - 1);
         end else if (load_hold) begin
            pre_q <= PRE_TOP;
            us_q  <= UW'(HOLD_US - 1);
         end else if (pre_q != '0) begin
            pre_q <= pre_q - 1'b1;
         end else if (us_q != '0) begin
            pre_q <= PRE_TOP;
            us_q  <= us_q - 1'b1;
         end
      end
      assign done = (us_q == '0) && (pre_q == '0);

      assert_pre_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
         pre_q <= PRE_TOP);
   end

endmodule

// File: rtl/lnk_phy_port.sv
module lnk_phy_port
   import lnk_pkg::*;
#(
   parameter int PHY_AW       = 16,
   parameter int PHY_DW       = 16,
   parameter int RX_STAT_ADDR = 'h100D,
   parameter int OVR_ADDR     = 'h1005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phy_op_e           op,
   input  logic [PHY_DW-1:0] shadow,
   input  logic              phy_ack,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata
);
   localparam logic [PHY_AW-1:0] RX_A  = PHY_AW'(RX_STAT_ADDR);
   localparam logic [PHY_AW-1:0] OVR_A = PHY_AW'(OVR_ADDR);

   always_comb begin
      phy_req   = 1'b0;
      phy_we    = 1'b0;
      phy_addr  = '0;
      phy_wdata = '0;
      case (op)
         OP_RD_RX: begin
            phy_req  = 1'b1;
            phy_addr = RX_A;
         end
         OP_RD_OVR: begin
            phy_req  = 1'b1;
            phy_addr = OVR_A;
         end
         OP_WR_OVR: begin
            phy_req   = 1'b1;
            phy_we    = 1'b1;
            phy_addr  = OVR_A;
            phy_wdata = shadow;
         end
         default: ;
      endcase
   end

   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we)
                                 && $stable(phy_wdata)));

endmodule

// File: rtl/lnk_train_guard.sv
module lnk_train_guard
   import lnk_pkg::*;
#(
   parameter int CYC_PER_US   = 100,
   parameter int POLL_US      = 10,
   parameter int HOLD_US      = 3000,
   parameter int MAX_POLLS    = 4000,
   parameter int DBG_W        = 32,
   parameter int UP_BIT       = 4,
   parameter int TRAIN_BIT    = 29,
   parameter int STATE_LSB    = 0,
   parameter int STATE_W      = 6,
   parameter int STALL_STATE  = 'h0D,
   parameter int PHY_AW       = 16,
   parameter int PHY_DW       = 16,
   parameter int RX_STAT_ADDR = 'h100D,
   parameter int OVR_ADDR     = 'h1005,
   parameter int RX_VALID_BIT = 0,
   parameter int OVR_MASK     = 'h0028
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DBG_W-1:0]  dbg_word0,
   input  logic [DBG_W-1:0]  dbg_word1,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata,
   output logic              link_up,
   output logic              link_fail,
   output logic              stuck_event
);
   localparam int                CNT_W = $clog2(MAX_POLLS + 1);
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(MAX_POLLS - 1);
   localparam logic [PHY_DW-1:0] MASK  = PHY_DW'(OVR_MASK);

   if (CYC_PER_US < 1)                    begin : g_bad_div   $error("CYC_PER_US must be >= 1"); end
   if (POLL_US < 1 || HOLD_US < 1)        begin : g_bad_int   $error("intervals must be >= 1"); end
   if (MAX_POLLS < 1)                     begin : g_bad_poll  $error("MAX_POLLS must be >= 1"); end
   if (UP_BIT >= DBG_W || TRAIN_BIT >= DBG_W) begin : g_bad_bit $error("flag bit outside word"); end
   if (STATE_LSB + STATE_W > DBG_W)       begin : g_bad_fld   $error("state field outside word"); end
   if (RX_VALID_BIT >= PHY_DW)            begin : g_bad_rxv   $error("valid bit outside data"); end

   guard_state_e      st_q, st_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [PHY_DW-1:0] shadow_q, shadow_d;
   logic              up_q, fail_q, stuck_q;
   logic              link_ok, at_stall, tmr_done;
   logic              ld_poll, ld_hold, fire, up_set, fail_set, cnt_inc, sh_ld;
   phy_op_e           op;

   lnk_dbg_decode #(
      .DBG_W(DBG_W), .UP_BIT(UP_BIT), .TRAIN_BIT(TRAIN_BIT),
      .STATE_LSB(STATE_LSB), .STATE_W(STATE_W), .STALL_STATE(STALL_STATE)
   ) u_decode (
      .dbg0(dbg_word0), .dbg1(dbg_word1), .link_ok(link_ok), .at_stall(at_stall)
   );

   lnk_interval_timer #(
      .CYC_PER_US(CYC_PER_US), .POLL_US(POLL_US), .HOLD_US(HOLD_US)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .load_poll(ld_poll), .load_hold(ld_hold), .done(tmr_done)
   );

   always_comb begin
      st_d     = st_q;
      ld_poll  = 1'b0;
      ld_hold  = 1'b0;
      fire     = 1'b0;
      up_set   = 1'b0;
      fail_set = 1'b0;
      cnt_inc  = 1'b0;
      sh_ld    = 1'b0;
      shadow_d = shadow_q;
      if (start) begin
         st_d = ST_CHECK;
      end else begin
         case (st_q)
            ST_CHECK: begin
               if (link_ok) begin
                  up_set = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  st_d = ST_RX_RD;
               end
            end
            ST_RX_RD: if (phy_ack) begin
               if (!phy_rdata[RX_VALID_BIT] && at_stall) begin
                  fire = 1'b1;
                  st_d = ST_OV_RD1;
               end else begin
                  ld_poll = 1'b1;
                  st_d    = ST_WAIT;
               end
            end
            ST_OV_RD1: if (phy_ack) begin
               sh_ld    = 1'b1;
               shadow_d = phy_rdata | MASK;
               st_d     = ST_OV_WR1;
            end
            ST_OV_WR1: if (phy_ack) begin
               ld_hold = 1'b1;
               st_d    = ST_HOLD;
            end
            ST_HOLD: if (tmr_done) st_d = ST_OV_RD2;
            ST_OV_RD2: if (phy_ack) begin
               sh_ld    = 1'b1;
               shadow_d = phy_rdata & ~MASK;
               st_d     = ST_OV_WR2;
            end
            ST_OV_WR2: if (phy_ack) begin
               ld_poll = 1'b1;
               st_d    = ST_WAIT;
            end
            ST_WAIT: if (tmr_done) begin
               if (cnt_q == LAST) begin
                  fail_set = 1'b1;
                  st_d     = ST_IDLE;
               end else begin
                  cnt_inc = 1'b1;
                  st_d    = ST_CHECK;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         shadow_q <= '0;
         up_q     <= 1'b0;
         fail_q   <= 1'b0;
         stuck_q  <= 1'b0;
      end else begin
         st_q    <= st_d;
         stuck_q <= fire;
         if (sh_ld) shadow_q <= shadow_d;
         if (start) begin
            cnt_q  <= '0;
            up_q   <= 1'b0;
            fail_q <= 1'b0;
         end else begin
            if (cnt_inc)  cnt_q  <= cnt_q + 1'b1;
            if (up_set)   up_q   <= 1'b1;
            if (fail_set) fail_q <= 1'b1;
         end
      end
   end

   always_comb begin
      case (st_q)
         ST_RX_RD:               op = OP_RD_RX;
         ST_OV_RD1, ST_OV_RD2:   op = OP_RD_OVR;
         ST_OV_WR1, ST_OV_WR2:   op = OP_WR_OVR;
         default:                op = OP_NONE;
      endcase
   end

   lnk_phy_port #(
      .PHY_AW(PHY_AW), .PHY_DW(PHY_DW), .RX_STAT_ADDR(RX_STAT_ADDR), .OVR_ADDR(OVR_ADDR)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .op(op), .shadow(shadow_q), .phy_ack(phy_ack),
      .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata)
   );

   assign link_up     = up_q;
   assign link_fail   = fail_q;
   assign stuck_event = stuck_q;

   assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_up && link_fail));
   assert_fail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_fail && !start) |=> link_fail);
   assert_up_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && !start) |=> link_up);
   assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!link_up && !link_fail));
   assert_stuck_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_event |=> !stuck_event);
   assert_stuck_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_event |-> (phy_req && !phy_we && phy_addr == PHY_AW'(OVR_ADDR)));
   assert_quiet_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up || link_fail) |-> !phy_req);
   assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: tb/lnk_train_guard_tb.sv
module lnk_train_guard_tb;
   localparam int CYC = 2, PU = 3, HU = 20, MAXP = 6;
   localparam int POLL_CYC = CYC * PU, HOLD_CYC = CYC * HU;
   localparam int S_IDL = 0, S_CHK = 1, S_RX = 2, S_R1 = 3, S_W1 = 4,
                  S_HD = 5, S_R2 = 6, S_W2 = 7, S_WT = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [31:0] dbg0 = '0, dbg1 = '0;
   logic phy_req, phy_we, phy_ack = 1'b0;
   logic [15:0] phy_addr, phy_wdata, phy_rdata = '0;
   logic link_up, link_fail, stuck_event;

   int checks = 0, failures = 0, cyc = 0, stuck_cnt = 0;
   logic [15:0] rx_reg = 16'h0001, ovr_reg = 16'h0000;
   logic [15:0] wr_log [$];
   int lat_seed = 0, wait_n = 0;

   int m_st = S_IDL, m_cnt = 0, m_tmr = 0;
   logic m_up = 0, m_fail = 0, m_stuck = 0;
   logic [15:0] m_sh = '0;

   always #2 clk = ~clk;

   lnk_train_guard #(.CYC_PER_US(CYC), .POLL_US(PU), .HOLD_US(HU), .MAX_POLLS(MAXP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dbg_word0(dbg0), .dbg_word1(dbg1),
      .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
      .phy_ack(phy_ack), .phy_rdata(phy_rdata), .link_up(link_up), .link_fail(link_fail),
      .stuck_event(stuck_event));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // behavioural reference, advanced on every rising edge from the inputs
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = S_IDL; m_cnt = 0; m_up = 0; m_fail = 0; m_stuck = 0;
      end else begin
         m_stuck = 0;
         if (start) begin
            m_st = S_CHK; m_up = 0; m_fail = 0; m_cnt = 0;
         end else begin
            case (m_st)
               S_CHK: if (dbg1[4] && !dbg1[29]) begin m_up = 1; m_st = S_IDL; end
                      else m_st = S_RX;
               S_RX: if (phy_ack) begin
                  if (!phy_rdata[0] && dbg0[5:0] == 6'h0D) begin m_stuck = 1; m_st = S_R1; end
                  else begin m_tmr = POLL_CYC; m_st = S_WT; end
               end
               S_R1: if (phy_ack) begin m_sh = phy_rdata | 16'h0028; m_st = S_W1; end
               S_W1: if (phy_ack) begin m_tmr = HOLD_CYC; m_st = S_HD; end
               S_HD: begin m_tmr--; if (m_tmr == 0) m_st = S_R2; end
               S_R2: if (phy_ack) begin m_sh = phy_rdata & ~16'h0028; m_st = S_W2; end
               S_W2: if (phy_ack) begin m_tmr = POLL_CYC; m_st = S_WT; end
               S_WT: begin
                  m_tmr--;
                  if (m_tmr == 0) begin
                     m_cnt++;
                     if (m_cnt == MAXP) begin m_fail = 1; m_st = S_IDL; end
                     else m_st = S_CHK;
                  end
               end
               default: m_st = S_IDL;
            endcase
         end
      end
   end

   // compare against the reference and play the PHY, away from the rising edge
   always @(negedge clk) begin
      logic e_req, e_we;
      logic [15:0] e_addr, e_wd;
      e_req  = (m_st == S_RX || m_st == S_R1 || m_st == S_W1 || m_st == S_R2 || m_st == S_W2);
      e_we   = (m_st == S_W1 || m_st == S_W2);
      e_addr = (m_st == S_RX) ? 16'h100D : (e_req ? 16'h1005 : 16'h0000);
      e_wd   = e_we ? m_sh : 16'h0000;
      check("R1 link_up", {31'b0, link_up}, {31'b0, m_up});
      check("R6 link_fail", {31'b0, link_fail}, {31'b0, m_fail});
      check("R4 stuck_event", {31'b0, stuck_event}, {31'b0, m_stuck});
      check("R8 phy_req", {31'b0, phy_req}, {31'b0, e_req});
      check("R2 phy_we", {31'b0, phy_we}, {31'b0, e_we});
      check("R2 phy_addr", {16'b0, phy_addr}, {16'b0, e_addr});
      check("R5 phy_wdata", {16'b0, phy_wdata}, {16'b0, e_wd});
      if (stuck_event) stuck_cnt++;
      if (phy_ack || !phy_req) begin
         phy_ack = 1'b0; wait_n = 0;
      end else if (wait_n >= lat_seed % 3) begin
         phy_ack = 1'b1; lat_seed++; wait_n = 0;
         phy_rdata = (phy_addr == 16'h100D) ? rx_reg : ovr_reg;
         if (phy_we) begin ovr_reg = phy_wdata; wr_log.push_back(phy_wdata); end
      end else wait_n++;
   end

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R7 status cleared after start", {30'b0, link_up, link_fail}, 32'd0);
      stuck_cnt = 0;
      wr_log.delete();
   endtask

   task automatic wait_status(int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (link_up || link_fail) break;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset outputs", {28'b0, link_up, link_fail, stuck_event, phy_req}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R8 idle no traffic", {31'b0, phy_req}, 32'd0);

      // immediate link up
      dbg1 = 32'h0000_0010;
      pulse_start();
      wait_status(100);
      check("R1 immediate up", {30'b0, link_up, link_fail}, 32'd2);

      // training flag masks up bit, receive valid present: no recovery, then link comes up
      dbg1 = 32'h2000_0010; dbg0 = 32'h0D; rx_reg = 16'h0001;
      pulse_start();
      repeat (40) @(negedge clk);
      check("R1 training blocks up", {31'b0, link_up}, 32'd0);
      dbg1 = 32'h0000_0010;
      wait_status(200);
      check("R1 up after training", {31'b0, link_up}, 32'd1);
      check("R3 no recovery with rx valid", stuck_cnt, 0);

      // stall: one recovery then link up
      dbg1 = 32'h0; dbg0 = 32'hC0D; rx_reg = 16'hFFFE; ovr_reg = 16'h1234;
      pulse_start();
      for (int i = 0; i < 2000 && wr_log.size() < 2; i++) @(negedge clk);
      dbg1 = 32'h0000_0010;
      wait_status(500);
      check("R4 one stuck pulse", stuck_cnt, 1);
      check("R4 first write sets enables", {16'b0, wr_log[0]}, 32'h123C);
      check("R5 second write clears enables", {16'b0, wr_log[1]}, 32'h1214);
      check("R1 up after recovery", {31'b0, link_up}, 32'd1);

      // wrong state field, no valid: no recovery, budget runs out
      dbg1 = 32'h0; dbg0 = 32'h0C; rx_reg = 16'h0000;
      pulse_start();
      wait_status(2000);
      check("R6 fail after poll budget", {30'b0, link_up, link_fail}, 32'd1);
      check("R3 no recovery off-state", stuck_cnt, 0);
      check("R3 no override writes", wr_log.size(), 0);
      repeat (10) @(negedge clk);
      check("R8 quiet after fail", {31'b0, phy_req}, 32'd0);

      // restart during hold, then persistent stall until failure
      dbg0 = 32'h0D; rx_reg = 16'h0000; ovr_reg = 16'h0001;
      pulse_start();
      for (int i = 0; i < 500 && wr_log.size() < 1; i++) @(negedge clk);
      repeat (5) @(negedge clk);
      pulse_start();
      wait_status(20000);
      check("R6 fail with persistent stall", {30'b0, link_up, link_fail}, 32'd1);
      check("R4 one recovery per poll", stuck_cnt, MAXP);
      check("R5 override restored", {16'b0, ovr_reg}, 32'h0001);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule